// File: doc/BRIEF.md
# Scoped-Fence Store Buffer Controller

This block is an eight-entry first-in, first-out store buffer placed between a core's commit stage and a single-port cache write port. Each committed store arrives with an address, data and a tag vector. The tag vector has four nested scope-level bits and one shared set-scope bit. Stores leave for the cache strictly in arrival order, one per completed ready/acknowledge handshake. A cache miss is modelled by holding the acknowledge low.

A fence request names one scope level, or the whole buffer. Once the fence is accepted, the controller looks only at the stores already buffered whose tag bit for that level is set. It raises a one-cycle completion pulse once the last of them has drained. Older stores outside the scope can stall on a miss without delaying the fence. Stores that arrive after the fence do not hold it back either. A global fence keeps the conventional behaviour and waits for every store that was buffered when it was accepted.

Top module: `sfsb_top`

## Requirements
- R1: After reset the buffer is empty (`drn_valid`=0, `enq_ready`=1), and `fence_busy`=0 and `fence_done`=0.
- R2: A store is accepted on a cycle with `enq_valid`=1 and `enq_ready`=1. `enq_ready` is 0 exactly while 8 stores are held, and a store offered while it is 0 is not taken.
- R3: `drn_valid` is 1 whenever a store is held, and `drn_addr`/`drn_data` show the oldest one. That store is removed on a cycle with `drn_valid`=1 and `drn_ack`=1, and stores leave in acceptance order.
- R4: A fence is accepted on a cycle with `fence_req`=1 and `fence_busy`=0. `fence_busy` is 1 from the next cycle through the cycle in which `fence_done` is 1.
- R5: For `fence_global`=0 and `fence_level` L in 0..3, the fence waits only for stores held at acceptance whose `enq_scope` bit L is set. `fence_done` is 1 for exactly one cycle: the first busy cycle in which none of those stores remain.
- R6: `fence_level`=4 selects the set-scope bit, `enq_scope` bit 4, which every set-scope store shares.
- R7: `fence_global`=1, or `fence_level` 5..7, makes the fence wait for every store held at acceptance, whatever its tag.
- R8: A store accepted in the same cycle as the fence, or later, does not delay that fence.
- R9: `fence_req` is ignored while `fence_busy`=1, including the cycle in which `fence_done`=1.
- R10: An older store whose scope bit for the fenced level is clear does not delay the fence, even while it waits at the head for `drn_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Commit stage offers a store |
| enq_ready | output | 1 | Buffer has a free entry |
| enq_addr | input | 32 | Store address |
| enq_data | input | 32 | Store data |
| enq_scope | input | 5 | Tag: bits 0..3 scope levels, bit 4 set scope |
| drn_valid | output | 1 | Oldest store is offered to the cache |
| drn_addr | output | 32 | Address of the oldest store |
| drn_data | output | 32 | Data of the oldest store |
| drn_ack | input | 1 | Cache takes the offered store |
| fence_req | input | 1 | Fence request |
| fence_global | input | 1 | Fence covers every buffered store |
| fence_level | input | 3 | Scope level 0..3, 4 for set scope, 5..7 act as global |
| fence_busy | output | 1 | A fence is outstanding |
| fence_done | output | 1 | One-cycle pulse: the fence may complete |

## Verification
The fence logic is driven with a full buffer whose head is stalled by a withheld acknowledge. A fence on an unused level must then finish at once, while a fence on a level used by the head must wait for the drain. That pair separates scoped waiting from a full-drain wait. Further patterns use a set-scope fence, a global fence and an out-of-range level under an alternating acknowledge, to show that each waits for exactly its own stores. A fence accepted together with a matching enqueue shows that later stores are excluded, and repeated requests while busy and in the completion cycle show that they are dropped. A scoreboard compares every drained address and data against acceptance order, including stores offered while the buffer is full.

// File: rtl/sfsb_pkg.sv
package sfsb_pkg;

    localparam int unsigned SB_ADDR_W  = 32;
    localparam int unsigned SB_DATA_W  = 32;
    localparam int unsigned SB_LVL_CNT = 4;
    localparam int unsigned SB_TAG_W   = SB_LVL_CNT + 1;
    localparam int unsigned SB_SET_LVL = SB_LVL_CNT;
    localparam int unsigned SB_SEL_W   = $clog2(SB_TAG_W);

    typedef logic [SB_TAG_W-1:0] scope_tag_t;

    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
        scope_tag_t           tag;
    } store_ent_t;

    typedef struct packed {
        logic                wide;
        logic [SB_SEL_W-1:0] level;
    } fence_sel_t;

    // Does a store with this tag fall under the given fence selection?
    function automatic logic sel_hits(scope_tag_t tag, fence_sel_t sel);
        logic hit;
        hit = 1'b0;
        if (sel.wide || (sel.level > SB_SEL_W'(SB_SET_LVL))) begin
            hit = 1'b1;
        end else begin
            for (int i = 0; i < SB_TAG_W; i++) begin
                if (sel.level == SB_SEL_W'(i)) hit = tag[i];
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/sfsb_ring.sv
module sfsb_ring
    import sfsb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  store_ent_t                    push_ent,
    input  logic                          pop,
    output store_ent_t                    head_ent,
    output logic                          full,
    output logic                          empty,
    output logic [DEPTH-1:0]              occ,
    output logic [DEPTH-1:0]              pop_vec,
    output logic [DEPTH-1:0][SB_TAG_W-1:0] tags
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    store_ent_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [DEPTH-1:0] occ_q;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            logic wr_here, rd_here;
            assign wr_here    = push && (wr_ptr == PTR_W'(s));
            assign rd_here    = pop  && (rd_ptr == PTR_W'(s));
            assign pop_vec[s] = rd_here;
            assign tags[s]    = mem[s].tag;

            always_ff @(posedge clk) begin
                if (rst) begin
                    occ_q[s] <= 1'b0;
                end else if (wr_here) begin
                    occ_q[s] <= 1'b1;
                end else if (rd_here) begin
                    occ_q[s] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (wr_here) mem[s] <= push_ent;
            end
        end
    endgenerate

    assign occ      = occ_q;
    assign full     = &occ_q;
    assign empty    = ~|occ_q;
    assign head_ent = mem[rd_ptr];

    // R2: an accepted store never lands on an occupied slot
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !occ_q[wr_ptr]);

    // R3: an unacknowledged head keeps its contents
    a_r3_head_stable: assert property (@(posedge clk) disable iff (rst)
        (!empty && !pop && !push) |=> (!empty && $stable(head_ent)));

endmodule

// File: rtl/sfsb_scope_match.sv
module sfsb_scope_match
    import sfsb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic [DEPTH-1:0]               occ,
    input  logic [DEPTH-1:0][SB_TAG_W-1:0] tags,
    input  fence_sel_t                     sel,
    output logic [DEPTH-1:0]               hit
);

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
            assign hit[s] = occ[s] && sel_hits(tags[s], sel);
        end
    endgenerate

endmodule

// File: rtl/sfsb_fence_ctl.sv
module sfsb_fence_ctl #(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [DEPTH-1:0] hit,
    input  logic [DEPTH-1:0] pop_vec,
    output logic             busy,
    output logic             done
);

    logic             active_q;
    logic [DEPTH-1:0] pend_q;

    assign busy = active_q;
    assign done = active_q && (pend_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pend_q   <= '0;
        end else if (active_q) begin
            if (done) active_q <= 1'b0;
            pend_q <= pend_q & ~pop_vec;
        end else if (req) begin
            active_q <= 1'b1;
            pend_q   <= hit & ~pop_vec;
        end
    end

    // R4: an accepted request makes the controller busy next cycle
    a_r4_busy_after_req: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a busy fence stays busy until it completes
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R8: the wait set never gains stores after acceptance
    a_r8_pending_shrinks: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/sfsb_top.sv
module sfsb_top
    import sfsb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enq_valid,
    output logic                 enq_ready,
    input  logic [SB_ADDR_W-1:0] enq_addr,
    input  logic [SB_DATA_W-1:0] enq_data,
    input  logic [SB_TAG_W-1:0]  enq_scope,
    output logic                 drn_valid,
    output logic [SB_ADDR_W-1:0] drn_addr,
    output logic [SB_DATA_W-1:0] drn_data,
    input  logic                 drn_ack,
    input  logic                 fence_req,
    input  logic                 fence_global,
    input  logic [SB_SEL_W-1:0]  fence_level,
    output logic                 fence_busy,
    output logic                 fence_done
);

    store_ent_t                     in_ent, head_ent;
    fence_sel_t                     sel;
    logic                           push, pop, full, empty;
    logic [DEPTH-1:0]               occ, pop_vec, hit;
    logic [DEPTH-1:0][SB_TAG_W-1:0] tags;

    assign in_ent    = '{addr: enq_addr, data: enq_data, tag: enq_scope};
    assign sel       = '{wide: fence_global, level: fence_level};
    assign enq_ready = !full;
    assign drn_valid = !empty;
    assign push      = enq_valid && enq_ready;
    assign pop       = drn_valid && drn_ack;
    assign drn_addr  = head_ent.addr;
    assign drn_data  = head_ent.data;

    sfsb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (in_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .full     (full),
        .empty    (empty),
        .occ      (occ),
        .pop_vec  (pop_vec),
        .tags     (tags)
    );

    sfsb_scope_match #(.DEPTH(DEPTH)) u_match (
        .occ  (occ),
        .tags (tags),
        .sel  (sel),
        .hit  (hit)
    );

    sfsb_fence_ctl #(.DEPTH(DEPTH)) u_fence (
        .clk     (clk),
        .rst     (rst),
        .req     (fence_req),
        .hit     (hit),
        .pop_vec (pop_vec),
        .busy    (fence_busy),
        .done    (fence_done)
    );

    // R3: the head leaves only through a handshake
    a_r3_hold_head: assert property (@(posedge clk) disable iff (rst)
        (drn_valid && !drn_ack) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data)));

endmodule

// File: tb/tb_sfsb_top.sv
module tb_sfsb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0, enq_ready;
    logic [31:0] enq_addr = '0, enq_data = '0;
    logic [4:0]  enq_scope = '0;
    logic        drn_valid, drn_ack = 1'b0;
    logic [31:0] drn_addr, drn_data;
    logic        fence_req = 1'b0, fence_global = 1'b0;
    logic [2:0]  fence_level = '0;
    logic        fence_busy, fence_done;

    int checks = 0, failures = 0, seq = 0, cycles = 0;
    string cur_req = "R1";

    logic [4:0]  m_q[$];
    logic [63:0] sb_q[$];
    logic        m_act = 1'b0, m_g = 1'b0;
    logic [2:0]  m_l = '0;
    int          m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfsb_top dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_addr(enq_addr), .enq_data(enq_data), .enq_scope(enq_scope),
        .drn_valid(drn_valid), .drn_addr(drn_addr), .drn_data(drn_data),
        .drn_ack(drn_ack),
        .fence_req(fence_req), .fence_global(fence_global),
        .fence_level(fence_level),
        .fence_busy(fence_busy), .fence_done(fence_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit mhit(logic [4:0] tg, logic g, logic [2:0] l);
        if (g || l > 3'd4) return 1'b1;
        return tg[l];
    endfunction

    // Monitor: every drained store must match the next expected item (R3)
    always @(posedge clk) begin
        if (!rst && drn_valid && drn_ack) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected drain", {drn_addr, drn_data}, 64'h0);
            end else begin
                logic [63:0] e;
                e = sb_q.pop_front();
                chk({drn_addr, drn_data} === e, "R3", "drain order", {drn_addr, drn_data}, e);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            chk(1'b0, "R1", "watchdog expired", 64'(cycles), 64'd20000);
            finish_run();
        end
    end

    // Driver: one cycle of stimulus plus the bench's own expectation model
    task automatic step(input logic ev, input logic [4:0] tg, input logic ak,
                        input logic fr, input logic fg, input logic [2:0] fl);
        logic exp_done, pop_now, enq_now;
        int   cnt;
        @(negedge clk);
        exp_done = m_act && (m_pend == 0);
        chk(fence_done === exp_done, cur_req, "fence_done", 64'(fence_done), 64'(exp_done));
        chk(fence_busy === m_act, "R4", "fence_busy", 64'(fence_busy), 64'(m_act));
        chk(enq_ready === (m_q.size() < DEPTH), "R2", "enq_ready",
            64'(enq_ready), 64'(m_q.size() < DEPTH));
        chk(drn_valid === (m_q.size() > 0), "R3", "drn_valid",
            64'(drn_valid), 64'(m_q.size() > 0));
        enq_valid    = ev;
        enq_scope    = tg;
        enq_addr     = 32'h4000_0000 + 32'(seq) * 4;
        enq_data     = 32'hA5A5_0000 ^ 32'(seq * 37);
        drn_ack      = ak;
        fence_req    = fr;
        fence_global = fg;
        fence_level  = fl;
        pop_now = ak && (m_q.size() > 0);
        enq_now = ev && (m_q.size() < DEPTH);
        if (m_act) begin
            if (exp_done) m_act = 1'b0;
            else if (pop_now && mhit(m_q[0], m_g, m_l)) m_pend--;
        end else if (fr) begin
            m_act = 1'b1; m_g = fg; m_l = fl; cnt = 0;
            foreach (m_q[i]) if (!(pop_now && i == 0) && mhit(m_q[i], fg, fl)) cnt++;
            m_pend = cnt;
        end
        if (pop_now) void'(m_q.pop_front());
        if (enq_now) begin
            m_q.push_back(tg);
            sb_q.push_back({enq_addr, enq_data});
            seq++;
        end
    endtask

    task automatic idle(input logic ak, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 5'b0, ak, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        logic [4:0] fill [8];
        fill = '{5'b00001, 5'b00010, 5'b00000, 5'b10000,
                 5'b00010, 5'b00001, 5'b00000, 5'b01000};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        idle(1'b0, 1);

        // R2: fill to capacity with a stalled cache, then offer two extra
        cur_req = "R2";
        for (int i = 0; i < 8; i++) step(1'b1, fill[i], 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 3'd0);

        // R10: level 2 is unused; the stalled head must not delay the fence
        cur_req = "R10";
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd2);
        idle(1'b0, 3);

        // R5: level 0 fence waits for slots 0 and 5; R9 repeated requests ignored
        cur_req = "R5";
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd0);
        cur_req = "R9";
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd1);
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd2);
        cur_req = "R5";
        for (int i = 0; i < 9; i++) step(1'b1, 5'b00001, 1'b1, 1'b0, 1'b0, 3'd0);
        idle(1'b1, 10);

        // R6: set-scope fence
        cur_req = "R6";
        step(1'b1, 5'b00010, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b1, 5'b10000, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b1, 5'b00100, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd4);
        idle(1'b0, 2);
        idle(1'b1, 5);

        // R7: global fence under alternating acknowledge
        cur_req = "R7";
        for (int i = 0; i < 3; i++) step(1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b1, 3'd1);
        for (int i = 0; i < 8; i++) step(1'b0, 5'b0, logic'(i % 2), 1'b0, 1'b0, 3'd0);
        idle(1'b1, 3);

        // R7: out-of-range level behaves as global
        for (int i = 0; i < 2; i++) step(1'b1, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd5);
        idle(1'b0, 2);
        idle(1'b1, 4);

        // R8: matching store accepted in the same cycle as the fence
        cur_req = "R8";
        step(1'b1, 5'b00010, 1'b0, 1'b1, 1'b0, 3'd1);
        step(1'b1, 5'b00010, 1'b0, 1'b0, 1'b0, 3'd0);
        idle(1'b0, 2);
        idle(1'b1, 4);

        // R9: request during the completion cycle is dropped
        cur_req = "R9";
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd3);
        step(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, 3'd3);
        idle(1'b0, 2);

        // R3: final drain, scoreboard must be empty
        cur_req = "R3";
        idle(1'b1, 4);
        chk(sb_q.size() == 0, "R3", "leftover expected stores", 64'(sb_q.size()), 64'd0);
        finish_run();
    end

endmodule